// File: doc/BRIEF.md
# Page Permission Check Unit

This block judges a single memory access against the attribute bits of a translation entry that a lookup has already matched. The entry's data bits arrive together with the global bit held in the entry's tag. The access arrives with its kind (instruction fetch, load or store), the current privilege level, and a flag that selects the instruction-side or data-side translator. One clock edge later the block returns its verdict: a trap request with a trap class and a fault-type code, a miss flag, a tag/data global consistency flag, the effective writable bit, and the cacheable indication.

The verdict is computed combinationally and captured in one output register stage. Each accepted request (`req_valid` high for one cycle) produces exactly one cycle of `chk_valid`. While `chk_valid` is low, all verdict outputs read as zero. Referenced and modified bookkeeping is left to software and does not take part in the check.

Top module: `perm_check_unit`

## Requirements
- R1: After synchronous reset, every output is 0.
- R2: `chk_valid` is 1 in the cycle after a cycle with `req_valid` 1, and 0 in the cycle after a cycle with `req_valid` 0. All verdict outputs are 0 whenever `chk_valid` is 0.
- R3: When the entry is valid, `ent_priv` is 1 and `priv_level` is 0 (user), the block raises `trap_req` with `fault_type` = 1. When `priv_level` is 1, this condition never traps.
- R4: The class of a privilege trap depends on `access_type` (0 = fetch, 1 = load, 2 = store, 3 = treated as load). A fetch gives class 1 (instruction access exception). A load or store gives class 2 (data access exception).
- R5: A store to a valid entry whose effective writable bit is 0, with no privilege violation, raises `trap_req` with class 3 (data protection) and `fault_type` 0.
- R6: When `instr_side` is 1, `eff_writable` is 0 whatever `ent_writable` holds. A store checked on the instruction side therefore always fails the write check. On the data side, `eff_writable` equals `ent_writable` for a valid entry.
- R7: When both the privilege condition and the write-protection condition hold, only the privilege trap (class 2, `fault_type` 1) is reported.
- R8: For a valid entry, `global_err` is 1 exactly when `ent_global` differs from `tag_global`. This flag never causes a trap on its own.
- R9: For a valid entry, `cacheable` equals `ent_cache_phys`, whatever `ent_side_effect` holds.
- R10: An entry with `ent_valid` 0 gives `miss` = 1, `trap_req` = 0, class 0, `fault_type` 0, and `global_err`, `cacheable` and `eff_writable` all 0.
- R11: A load or fetch never raises a data protection trap, and an access that is neither privileged-faulting nor a failing store gives class 0 with `trap_req` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access to check this cycle |
| access_type | input | 2 | 0 fetch, 1 load, 2 store, 3 treated as load |
| priv_level | input | 1 | 1 supervisor, 0 user |
| instr_side | input | 1 | 1 selects the instruction-side translator |
| ent_valid | input | 1 | Entry valid bit |
| ent_priv | input | 1 | Entry privileged bit |
| ent_writable | input | 1 | Entry writable bit |
| ent_global | input | 1 | Global bit from entry data |
| ent_side_effect | input | 1 | Side-effect bit |
| ent_cache_phys | input | 1 | Physically cacheable bit |
| ent_cache_virt | input | 1 | Virtually cacheable bit (passes through unchecked) |
| tag_global | input | 1 | Global bit from entry tag |
| chk_valid | output | 1 | Verdict valid, one cycle per request |
| trap_req | output | 1 | Trap requested |
| trap_class | output | 2 | 0 none, 1 instr access, 2 data access, 3 data protection |
| fault_type | output | 4 | Fault-type code, 1 for privilege violation |
| miss | output | 1 | Entry was invalid |
| global_err | output | 1 | Tag/data global mismatch |
| cacheable | output | 1 | Cacheability of the access |
| eff_writable | output | 1 | Writable bit as seen by the selected side |

## Verification
On every cycle, the assertions check the following:
- the one-cycle pairing of requests and verdicts;
- that a miss never traps;
- that a privilege-class trap always carries fault type 1;
- that the privilege trap outranks write protection.

Only the bench's scenarios can show the rest: the exact class chosen per access type, that the writable bit is suppressed on the instruction side, the global consistency flag, and that the side-effect bit leaves cacheability untouched. These are compared against a reference model over random and directed entries.

// File: rtl/perm_pkg.sv
package perm_pkg;

    localparam int FT_W = 4;
    localparam logic [FT_W-1:0] FT_NONE = '0;
    localparam logic [FT_W-1:0] FT_PRIV = FT_W'(1);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        TC_NONE  = 2'd0,
        TC_IACC  = 2'd1,
        TC_DACC  = 2'd2,
        TC_DPROT = 2'd3
    } tcls_e;

    typedef struct packed {
        logic valid;
        logic priv;
        logic writable;
        logic global_b;
        logic side_eff;
        logic cache_phys;
        logic cache_virt;
    } ent_t;

    typedef struct packed {
        logic            trap;
        tcls_e           cls;
        logic [FT_W-1:0] ft;
        logic            miss;
        logic            gerr;
        logic            cacheable;
        logic            eff_w;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{trap: 1'b0, cls: TC_NONE, ft: FT_NONE,
                                          miss: 1'b0, gerr: 1'b0, cacheable: 1'b0,
                                          eff_w: 1'b0};

    function automatic tcls_e access_fault_class(acc_e a);
        return (a == ACC_FETCH) ? TC_IACC : TC_DACC;
    endfunction

endpackage

// File: rtl/perm_attr_decode.sv
module perm_attr_decode
    import perm_pkg::*;
(
    input  ent_t ent,
    input  logic tag_global,
    input  logic instr_side,
    output logic eff_w,
    output logic cacheable,
    output logic gerr
);
    always_comb begin
        eff_w     = ent.valid & ~instr_side & ent.writable;
        cacheable = ent.valid & ent.cache_phys;
        gerr      = ent.valid & (ent.global_b ^ tag_global);
    end
endmodule

// File: rtl/perm_trap_select.sv
module perm_trap_select
    import perm_pkg::*;
(
    input  ent_t            ent,
    input  acc_e            acc,
    input  logic            priv_level,
    input  logic            eff_w,
    output logic            trap,
    output tcls_e           cls,
    output logic [FT_W-1:0] ft
);
    logic priv_viol;
    logic prot_viol;

    always_comb begin
        priv_viol = ent.valid & ent.priv & ~priv_level;
        prot_viol = ent.valid & (acc == ACC_STORE) & ~eff_w;
        trap = 1'b0;
        cls  = TC_NONE;
        ft   = FT_NONE;
        if (priv_viol) begin
            trap = 1'b1;
            cls  = access_fault_class(acc);
            ft   = FT_PRIV;
        end else if (prot_viol) begin
            trap = 1'b1;
            cls  = TC_DPROT;
        end
    end
endmodule

// File: rtl/perm_out_reg.sv
module perm_out_reg
    import perm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  verdict_t d,
    output logic     q_valid,
    output verdict_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= VERDICT_IDLE;
        end else begin
            q_valid <= req_valid;
            q       <= req_valid ? d : VERDICT_IDLE;
        end
    end

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> q_valid); // R2
    AST_IDLE_AFTER_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!q_valid && q == VERDICT_IDLE)); // R2
    AST_MISS_NEVER_TRAPS: assert property (@(posedge clk) disable iff (rst)
        q.miss |-> (!q.trap && q.cls == TC_NONE)); // R10
    AST_ACCESS_FT_CODE: assert property (@(posedge clk) disable iff (rst)
        (q.cls == TC_IACC || q.cls == TC_DACC) |-> (q.ft == FT_PRIV && q.trap)); // R3
endmodule

// File: rtl/perm_check_unit.sv
module perm_check_unit
    import perm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] access_type,
    input  logic       priv_level,
    input  logic       instr_side,
    input  logic       ent_valid,
    input  logic       ent_priv,
    input  logic       ent_writable,
    input  logic       ent_global,
    input  logic       ent_side_effect,
    input  logic       ent_cache_phys,
    input  logic       ent_cache_virt,
    input  logic       tag_global,
    output logic       chk_valid,
    output logic       trap_req,
    output logic [1:0] trap_class,
    output logic [3:0] fault_type,
    output logic       miss,
    output logic       global_err,
    output logic       cacheable,
    output logic       eff_writable
);
    ent_t            ent;
    acc_e            acc;
    logic            d_eff_w, d_cach, d_gerr, d_trap;
    tcls_e           d_cls;
    logic [FT_W-1:0] d_ft;
    verdict_t        d_verdict, q_verdict;

    always_comb begin
        ent = '{valid: ent_valid, priv: ent_priv, writable: ent_writable,
                global_b: ent_global, side_eff: ent_side_effect,
                cache_phys: ent_cache_phys, cache_virt: ent_cache_virt};
        acc = acc_e'(access_type);
    end

    perm_attr_decode u_decode (
        .ent        (ent),
        .tag_global (tag_global),
        .instr_side (instr_side),
        .eff_w      (d_eff_w),
        .cacheable  (d_cach),
        .gerr       (d_gerr)
    );

    perm_trap_select u_select (
        .ent        (ent),
        .acc        (acc),
        .priv_level (priv_level),
        .eff_w      (d_eff_w),
        .trap       (d_trap),
        .cls        (d_cls),
        .ft         (d_ft)
    );

    always_comb begin
        d_verdict = '{trap: d_trap, cls: d_cls, ft: d_ft, miss: ~ent_valid,
                      gerr: d_gerr, cacheable: d_cach, eff_w: d_eff_w};
    end

    perm_out_reg u_oreg (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .d         (d_verdict),
        .q_valid   (chk_valid),
        .q         (q_verdict)
    );

    always_comb begin
        trap_req     = q_verdict.trap;
        trap_class   = q_verdict.cls;
        fault_type   = q_verdict.ft;
        miss         = q_verdict.miss;
        global_err   = q_verdict.gerr;
        cacheable    = q_verdict.cacheable;
        eff_writable = q_verdict.eff_w;
    end

    AST_PRIV_OUTRANKS_PROT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ent_valid && ent_priv && !priv_level && access_type == 2'd2)
        |=> (trap_class == 2'd2 && fault_type == 4'd1)); // R7
    AST_ISIDE_STORE_PROT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ent_valid && instr_side && access_type == 2'd2 &&
         (priv_level || !ent_priv)) |=> (trap_req && trap_class == 2'd3)); // R6
    AST_NO_PROT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && access_type != 2'd2) |=> (trap_class != 2'd3)); // R11
endmodule

// File: tb/perm_check_unit_bench.sv
module perm_check_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] access_type = '0;
    logic priv_level = 1'b0, instr_side = 1'b0;
    logic ent_valid = 1'b0, ent_priv = 1'b0, ent_writable = 1'b0, ent_global = 1'b0;
    logic ent_side_effect = 1'b0, ent_cache_phys = 1'b0, ent_cache_virt = 1'b0, tag_global = 1'b0;
    logic chk_valid, trap_req, miss, global_err, cacheable, eff_writable;
    logic [1:0] trap_class;
    logic [3:0] fault_type;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_check_unit u_perm_check_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .access_type(access_type),
        .priv_level(priv_level), .instr_side(instr_side), .ent_valid(ent_valid),
        .ent_priv(ent_priv), .ent_writable(ent_writable), .ent_global(ent_global),
        .ent_side_effect(ent_side_effect), .ent_cache_phys(ent_cache_phys),
        .ent_cache_virt(ent_cache_virt), .tag_global(tag_global),
        .chk_valid(chk_valid), .trap_req(trap_req), .trap_class(trap_class),
        .fault_type(fault_type), .miss(miss), .global_err(global_err),
        .cacheable(cacheable), .eff_writable(eff_writable)
    );

    // packed layout: {chk_valid, trap, class[1:0], ft[3:0], miss, gerr, cacheable, eff_w}
    function automatic logic [11:0] expect_verdict(
        input logic [1:0] acc, input logic pl, input logic iside, input logic v,
        input logic p, input logic w, input logic g, input logic cp, input logic tg);
        logic tr; logic [1:0] cl; logic [3:0] ft; logic ew;
        tr = 0; cl = 0; ft = 0;
        if (!v) return {1'b1, 7'b0, 1'b1, 3'b0};          // R10
        ew = iside ? 1'b0 : w;                              // R6
        if (p && !pl) begin                                 // R3, R7
            tr = 1; ft = 4'd1;
            cl = (acc == 2'd0) ? 2'd1 : 2'd2;               // R4
        end else if (acc == 2'd2 && !ew) begin              // R5
            tr = 1; cl = 2'd3;
        end
        return {1'b1, tr, cl, ft, 1'b0, g ^ tg, cp, ew};    // R8, R9, R11
    endfunction

    function automatic logic [11:0] observed();
        return {chk_valid, trap_req, trap_class, fault_type, miss, global_err,
                cacheable, eff_writable};
    endfunction

    task automatic check(input string req, input logic [11:0] exp);
        n_cmp++;
        if (observed() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, observed(), exp);
        end
    endtask

    task automatic apply(input string req, input logic [1:0] acc, input logic pl,
                         input logic iside, input logic v, input logic p, input logic w,
                         input logic g, input logic se, input logic cp, input logic cv,
                         input logic tg);
        @(negedge clk);
        req_valid = 1; access_type = acc; priv_level = pl; instr_side = iside;
        ent_valid = v; ent_priv = p; ent_writable = w; ent_global = g;
        ent_side_effect = se; ent_cache_phys = cp; ent_cache_virt = cv; tag_global = tg;
        @(negedge clk);
        req_valid = 0;
        check(req, expect_verdict(acc, pl, iside, v, p, w, g, cp, tg));
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset", 12'b0);
        rst = 0;
        @(negedge clk);
        check("R2 idle no request", 12'b0);
        // directed corners
        apply("R3 user fetch priv page", 2'd0, 0, 1, 1, 1, 0, 0, 0, 1, 0, 0);
        apply("R4 user load priv page", 2'd1, 0, 0, 1, 1, 1, 1, 0, 1, 1, 1);
        apply("R3 supervisor priv ok", 2'd1, 1, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        apply("R5 store readonly", 2'd2, 1, 0, 1, 0, 0, 0, 0, 1, 0, 0);
        apply("R7 priv beats prot", 2'd2, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        apply("R6 iside store with W set", 2'd2, 1, 1, 1, 0, 1, 0, 0, 0, 0, 0);
        apply("R6 iside fetch W hidden", 2'd0, 1, 1, 1, 0, 1, 1, 0, 1, 0, 1);
        apply("R8 global mismatch no trap", 2'd1, 1, 0, 1, 0, 1, 1, 0, 1, 0, 0);
        apply("R9 side effect cacheable", 2'd1, 1, 0, 1, 0, 1, 0, 1, 1, 0, 0);
        apply("R9 side effect uncacheable", 2'd1, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0);
        apply("R10 invalid entry", 2'd2, 0, 0, 0, 1, 0, 1, 1, 1, 1, 0);
        apply("R11 load readonly no prot", 2'd1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        apply("R11 data store writable", 2'd2, 1, 0, 1, 0, 1, 0, 0, 1, 0, 0);
        @(negedge clk);
        check("R2 single cycle valid", 12'b0);
        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            a = 2'($urandom_range(0, 2));
            apply("R3-model random", a, 1'($urandom), 1'($urandom), ($urandom_range(0, 7) != 0),
                  1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check("R2 gap", 12'b0);
            end
        end
        apply("R4 reserved type as load", 2'd3, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule